// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between a bank of free-running source clocks and the loads they feed. It stops and restarts all of those clocks together, under the control of an active-low power-down pin. Each output can also be held off on its own by an enable bit.

The power-down pin is sampled on the rising edge of a reference CPU clock. A request only takes effect after two samples in a row agree. This filters out single-cycle noise on the pin in both directions.

Every output has its own gate, which is a latch that is open while that output's source clock is low. Because of this, an output only stops or starts at a low phase of its own source. A high pulse is never cut short, and no short pulse is created on restart. A status flag reports when the block is powered down and every output has come to rest low.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While `rst_n` is low, every output follows its source clock, whatever value `en_mask` has. The internal enable state resets to all ones.
- R2: Power-down starts only after `pd_n` is sampled low on two consecutive rising edges of `cpu_clk`. A low level seen on only one rising edge has no effect.
- R3: Leaving power-down requires `pd_n` to be sampled high on two consecutive rising edges of `cpu_clk`. A single high sample while powered down has no effect.
- R4: When outputs stop, each output finishes its current high phase at full width. It then stays low for as long as power-down or its disable lasts.
- R5: When outputs restart, they do so at a rising edge of their source. Every high pulse is exactly half the source period, so there are no runt pulses.
- R6: Bit i of `en_mask` is registered on `cpu_clk`. A value of 1 makes output i follow `src_clk[i]`. A value of 0 holds output i low, using the same glitch-free stop as power-down.
- R7: `pd_status` is 1 only while power-down is in effect and every output has been seen parked low. It falls at the `cpu_clk` edge that takes the second consecutive high sample of `pd_n`.
- R8: `pd_status` is 0 during reset and right after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Reference clock that samples the power-down pin |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Power-down request, active low |
| src_clk | input | N_OUT | Free-running source clocks |
| en_mask | input | N_OUT | Per-output enable, 1 = run |
| gclk | output | N_OUT | Gated output clocks |
| pd_status | output | 1 | Powered down with all outputs parked low |

## Verification
The assertions are checked on every reference-clock cycle. They cover the two-sample qualification for both entry to and exit from power-down, the rule that `pd_status` implies every output is low, and the rule that the status flag cannot be set without an active stop.

Some behaviour happens in the source clock domains and can only be shown by the bench's scenarios. These are:
- that each output tracks its source while it is enabled;
- that no high pulse is ever shorter than half a source period, across stops, restarts and mask changes;
- that single-sample pulses on `pd_n` are ignored;
- that the enable mask has no effect during reset.

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
module clk_stop_ctrl #(
  parameter int N_OUT     = 4,
  parameter int PARK_SYNC = 2
) (
  input  logic             cpu_clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic [N_OUT-1:0] src_clk,
  input  logic [N_OUT-1:0] en_mask,
  output logic [N_OUT-1:0] gclk,
  output logic             pd_status
);

  logic             pd_last;
  logic             stop_req;
  logic [N_OUT-1:0] en_q;
  logic [N_OUT-1:0] run;
  logic [N_OUT-1:0] parked;
  logic [N_OUT-1:0] park_pipe [PARK_SYNC];

  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_last  <= 1'b1;
      stop_req <= 1'b0;
      en_q     <= '1;
    end else begin
      pd_last <= pd_n;
      en_q    <= en_mask;
      if (!pd_n && !pd_last)
        stop_req <= 1'b1;
      else if (pd_n && pd_last)
        stop_req <= 1'b0;
    end
  end

  assign run = en_q & {N_OUT{~stop_req}};

  for (genvar g = 0; g < N_OUT; g++) begin : gen_out
    logic gate;
    always_latch begin
      if (!src_clk[g]) gate <= run[g];
    end
    assign gclk[g]   = src_clk[g] & gate;
    assign parked[g] = ~gate;
  end

  // the park pipeline is flushed whenever no stop is pending, so stale samples never count
  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < PARK_SYNC; s++) park_pipe[s] <= '0;
    end else if (!stop_req) begin
      for (int s = 0; s < PARK_SYNC; s++) park_pipe[s] <= '0;
    end else begin
      park_pipe[0] <= parked;
      for (int s = 1; s < PARK_SYNC; s++) park_pipe[s] <= park_pipe[s-1];
    end
  end

  assign pd_status = stop_req & (&park_pipe[PARK_SYNC-1]);

endmodule

// File: rtl/clk_stop_chk.sv
`timescale 1ns/1ps
module clk_stop_chk #(
  parameter int N = 4
) (
  input logic         cpu_clk,
  input logic         rst_n,
  input logic         pd_n,
  input logic         stop_req,
  input logic [N-1:0] gclk,
  input logic         pd_status
);

  assert_enter_two_low_R2: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    ($past(rst_n) && !pd_n && !$past(pd_n)) |=> stop_req);

  assert_exit_two_high_R3: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    ($past(rst_n) && pd_n && $past(pd_n)) |=> !stop_req);

  assert_parked_low_R4: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    pd_status |-> (gclk == '0));

  assert_status_needs_stop_R7: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    !stop_req |-> !pd_status);

endmodule

bind clk_stop_ctrl clk_stop_chk #(.N(N_OUT)) u_chk (
  .cpu_clk(cpu_clk), .rst_n(rst_n), .pd_n(pd_n),
  .stop_req(stop_req), .gclk(gclk), .pd_status(pd_status)
);

// File: tb/tb_clk_stop_ctrl.sv
`timescale 1ns/1ps
module tb_clk_stop_ctrl;
  localparam int N = 4;

  logic cpu_clk = 0, rst_n = 0, pd_n = 1;
  logic [N-1:0] en_mask = '0;
  logic s0 = 0, s1 = 0, s2 = 0, s3 = 0;
  logic [N-1:0] src;
  logic [N-1:0] gclk;
  logic pd_status;
  int checks = 0, errors = 0;
  int runt [N];
  real t_up [N];
  logic [N-1:0] prev = '0;
  bit done = 0;

  assign src = {s3, s2, s1, s0};

  always #10 cpu_clk = ~cpu_clk;
  always #7  s0 = ~s0;
  always #11 s1 = ~s1;
  always #15 s2 = ~s2;
  always #18 s3 = ~s3;

  clk_stop_ctrl #(.N_OUT(N)) dut (
    .cpu_clk(cpu_clk), .rst_n(rst_n), .pd_n(pd_n), .src_clk(src),
    .en_mask(en_mask), .gclk(gclk), .pd_status(pd_status)
  );

  function automatic real half(int i);
    case (i)
      0: return 7.0;
      1: return 11.0;
      2: return 15.0;
      default: return 18.0;
    endcase
  endfunction

  initial for (int i = 0; i < N; i++) begin runt[i] = 0; t_up[i] = 0.0; end

  // every high pulse of an output must last exactly half its source period
  always @(gclk) begin
    for (int i = 0; i < N; i++) begin
      if (gclk[i] && !prev[i]) t_up[i] = $realtime;
      else if (!gclk[i] && prev[i]) begin
        if (($realtime - t_up[i]) < half(i) - 0.01 || ($realtime - t_up[i]) > half(i) + 0.01)
          runt[i]++;
      end
    end
    prev = gclk;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge cpu_clk);
  endtask

  task automatic window(logic [N-1:0] exp_run, int ns, string req);
    int bad [N];
    for (int i = 0; i < N; i++) bad[i] = 0;
    #0.5;
    repeat (ns) begin
      for (int i = 0; i < N; i++)
        if (gclk[i] !== (exp_run[i] ? src[i] : 1'b0)) bad[i]++;
      #1;
    end
    for (int i = 0; i < N; i++)
      chk(bad[i] == 0, req, $sformatf("output %0d mismatched samples", i), bad[i], 0);
    @(negedge cpu_clk);
  endtask

  task automatic t_reset();
    rst_n = 0; en_mask = 4'b0000;
    cyc(5);
    window(4'hF, 200, "R1");
    chk(pd_status == 1'b0, "R8", "pd_status in reset", pd_status, 0);
    @(negedge cpu_clk); rst_n = 1; en_mask = 4'hF;
    #1 chk(pd_status == 1'b0, "R8", "pd_status after reset", pd_status, 0);
    cyc(3);
  endtask

  task automatic t_run();
    window(4'hF, 300, "R6");
  endtask

  task automatic t_single_low();
    @(negedge cpu_clk); pd_n = 0;
    @(negedge cpu_clk); pd_n = 1;
    cyc(6);
    chk(pd_status == 1'b0, "R2", "pd_status after one low sample", pd_status, 0);
    window(4'hF, 200, "R2");
  endtask

  task automatic t_enter();
    @(negedge cpu_clk); pd_n = 0;
    @(negedge cpu_clk);
    chk(pd_status == 1'b0, "R2", "pd_status after first low sample", pd_status, 0);
    cyc(5);
    chk(pd_status == 1'b1, "R7", "pd_status once parked", pd_status, 1);
    window(4'h0, 300, "R4");
  endtask

  task automatic t_single_high();
    @(negedge cpu_clk); pd_n = 1;
    @(negedge cpu_clk); pd_n = 0;
    cyc(4);
    chk(pd_status == 1'b1, "R3", "pd_status after one high sample", pd_status, 1);
    window(4'h0, 200, "R3");
  endtask

  task automatic t_exit();
    @(negedge cpu_clk); pd_n = 1;
    @(negedge cpu_clk);
    chk(pd_status == 1'b1, "R3", "pd_status after first high sample", pd_status, 1);
    @(negedge cpu_clk);
    chk(pd_status == 1'b0, "R7", "pd_status after second high sample", pd_status, 0);
    cyc(3);
    window(4'hF, 300, "R5");
  endtask

  task automatic t_mask();
    en_mask = 4'b0101;
    cyc(3);
    window(4'b0101, 300, "R6");
  endtask

  task automatic t_pd_masked();
    pd_n = 0;
    cyc(6);
    chk(pd_status == 1'b1, "R7", "pd_status with partial mask", pd_status, 1);
    window(4'h0, 200, "R4");
    en_mask = 4'b1010;
    cyc(3);
    window(4'h0, 150, "R4");
    pd_n = 1;
    cyc(4);
    chk(pd_status == 1'b0, "R7", "pd_status after resume", pd_status, 0);
    window(4'b1010, 300, "R5");
  endtask

  initial begin
    t_reset();
    t_run();
    t_single_low();
    t_enter();
    t_single_high();
    t_exit();
    t_mask();
    t_pd_masked();
    for (int i = 0; i < N; i++)
      chk(runt[i] == 0, "R5", $sformatf("output %0d short high pulses", i), runt[i], 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule